// File: doc/BRIEF.md
# GPIO Edge Interrupt Flag Unit

This block monitors thirty-two general-purpose input pins, grouped as four ports of eight, and keeps one sticky flag bit per pin. A flag bit sets when its pin makes the transition chosen for it: a rising edge, a falling edge, or either edge. Each pin is first synchronised to the block clock, and edges are found by comparing successive synchronised samples. Flags latch whether or not the pin's interrupt is enabled. A single interrupt output stays high while any flagged pin is also enabled.

Software reaches the block over a single-cycle register bus. The bus has an address, a write strobe, a read strobe, 32-bit write data and registered read data. Software clears flags in two ways. It can write ones to the flag register. It can also read the offset register, which returns a code naming the lowest-numbered pending enabled pin and clears that pin's flag in the same cycle. If an edge arrives in the same cycle as a clear of that bit, the edge wins and the flag stays set.

Top module: `gpio_edge_flags`

## Requirements
- R1: After reset, the flag register reads 0, the offset register reads 0, every control register reads 0 and `irq` is low.
- R2: When a pin's both-edge bit is 0 and its polarity bit is 1, a rising edge on the pin sets its flag and a falling edge does not.
- R3: When a pin's both-edge bit is 0 and its polarity bit is 0, a falling edge on the pin sets its flag and a rising edge does not.
- R4: When a pin's both-edge bit is 1, a rising edge sets its flag and so does a falling edge, whatever its polarity bit holds.
- R5: A pin change that is stable before clock edge k makes the flag, and with it `irq` if the pin is enabled, visible after edge k+2 and not after edge k+1.
- R6: A write to address 3 (flag register) clears every flag bit whose write-data bit is 1. Flag bits whose write-data bit is 0 are left unchanged.
- R7: Flags set whether or not the pin is enabled. `irq` is high exactly while some bit is set in both the flag register and the enable register (address 0).
- R8: A read of address 4 (offset register) returns the pin index + 1 of the lowest-numbered pin that is both flagged and enabled, or 0 if no such pin exists. The read clears only that pin's flag.
- R9: When a pin's selected edge sets its flag in the same cycle as a write-one clear or an offset-read clear of that bit, the flag remains 1.
- R10: The enable register (address 0), both-edge register (address 1) and polarity register (address 2) read back the value last written. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`.
- R11: Flag bit p*8+b belongs to port p (0 to 3) pin b (0 to 7), where `pin_in` bit p*8+b carries that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Asynchronous pin levels, port p pin b at bit p*8+b |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | High while any enabled pin is flagged |

## Verification
A pin change reaches the flag after three clock edges: two synchroniser stages, then the flag register. The bench therefore changes pins at a falling edge and waits three rising edges before it inspects the flag. It samples `irq` just after the second and the third of those edges to pin down this latency. Register reads return data after one clock edge, and the bench samples `bus_rdata` at the following falling edge. For the same-cycle collision cases, the bench starts the clear on the bus so that it is sampled at the third edge after the pin change, the same edge at which the flag is set.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;

    localparam int NUM_PORTS = 4;
    localparam int PORT_W    = 8;
    localparam int NPINS     = NUM_PORTS * PORT_W;
    localparam int CODE_W    = $clog2(NPINS + 1);
    localparam int ADDR_W    = 3;
    localparam int SYNC_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_ENABLE = 3'd0,
        ADR_BOTH   = 3'd1,
        ADR_POL    = 3'd2,
        ADR_FLAGS  = 3'd3,
        ADR_OFFSET = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [NPINS-1:0] enable;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] rising;
    } pin_cfg_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [ADDR_W-1:0] addr;
        logic [NPINS-1:0] wdata;
    } bus_req_t;

    // One-hot mask for an offset code; code 0 selects nothing.
    function automatic logic [NPINS-1:0] code_to_mask(input logic [CODE_W-1:0] code);
        logic [NPINS-1:0] m;
        m = '0;
        if (code != '0) begin
            m = {{(NPINS-1){1'b0}}, 1'b1} << (code - 1'b1);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_flag_pkg::*;
#(
    parameter int W = NPINS,
    parameter int STAGES = SYNC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0] chain_q [W];

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q[i] <= '0;
            end else begin
                chain_q[i] <= {chain_q[i][STAGES-2:0], async_in[i]};
            end
        end
        assign sync_out[i] = chain_q[i][STAGES-1];
    end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_flag_pkg::*;
#(
    parameter int W = NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] both,
    input  logic [W-1:0] rising,
    output logic [W-1:0] hit
);

    logic [W-1:0] prev_q;
    logic [W-1:0] up;
    logic [W-1:0] down;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= level;
        end
    end

    assign up   = level & ~prev_q;
    assign down = ~level & prev_q;

    for (genvar i = 0; i < W; i++) begin : g_sel
        always_comb begin
            if (both[i]) begin
                hit[i] = up[i] | down[i];
            end else if (rising[i]) begin
                hit[i] = up[i];
            end else begin
                hit[i] = down[i];
            end
        end
    end

endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank
    import gpio_flag_pkg::*;
#(
    parameter int W = NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);

    // Set takes priority so that an edge coinciding with a clear is kept.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end

endmodule

// File: rtl/gpio_prio_encoder.sv
module gpio_prio_encoder
    import gpio_flag_pkg::*;
#(
    parameter int W  = NPINS,
    parameter int CW = CODE_W
) (
    input  logic [W-1:0]  req,
    output logic [CW-1:0] code
);

    // Lowest index wins: scan downward so the last match is the lowest.
    always_comb begin
        code = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                code = CW'(i + 1);
            end
        end
    end

endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags
    import gpio_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq
);

    pin_cfg_t          cfg_q;
    bus_req_t          req;
    logic [NPINS-1:0]  pin_sync;
    logic [NPINS-1:0]  hit_w;
    logic [NPINS-1:0]  flag_q;
    logic [NPINS-1:0]  pending;
    logic [CODE_W-1:0] ofs_code;
    logic [NPINS-1:0]  clr_wr;
    logic [NPINS-1:0]  clr_ofs;
    logic              ofs_read;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};

    gpio_pin_sync #(.W(NPINS), .STAGES(SYNC_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_edge_detect #(.W(NPINS)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .level  (pin_sync),
        .both   (cfg_q.both),
        .rising (cfg_q.rising),
        .hit    (hit_w)
    );

    assign pending = flag_q & cfg_q.enable;

    gpio_prio_encoder #(.W(NPINS), .CW(CODE_W)) u_prio (
        .req  (pending),
        .code (ofs_code)
    );

    assign ofs_read = req.rd && (req.addr == ADR_OFFSET);
    assign clr_ofs  = ofs_read ? code_to_mask(ofs_code) : '0;
    assign clr_wr   = (req.wr && (req.addr == ADR_FLAGS)) ? req.wdata : '0;

    gpio_flag_bank #(.W(NPINS)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (hit_w),
        .clr   (clr_wr | clr_ofs),
        .flags (flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (req.wr) begin
            case (req.addr)
                ADR_ENABLE: cfg_q.enable <= req.wdata;
                ADR_BOTH:   cfg_q.both   <= req.wdata;
                ADR_POL:    cfg_q.rising <= req.wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (req.rd) begin
            case (req.addr)
                ADR_ENABLE: bus_rdata <= cfg_q.enable;
                ADR_BOTH:   bus_rdata <= cfg_q.both;
                ADR_POL:    bus_rdata <= cfg_q.rising;
                ADR_FLAGS:  bus_rdata <= flag_q;
                ADR_OFFSET: bus_rdata <= NPINS'(ofs_code);
                default:    bus_rdata <= '0;
            endcase
        end
    end

    assign irq = |pending;

endmodule

// File: rtl/gpio_edge_flags_chk.sv
module gpio_edge_flags_chk
    import gpio_flag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NPINS-1:0]  flags,
    input logic [NPINS-1:0]  hits,
    input logic [NPINS-1:0]  enable,
    input logic [CODE_W-1:0] code,
    input logic              irq,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata
);

    logic             wr_flags;
    logic             rd_ofs;
    logic [NPINS-1:0] ofs_mask;

    assign wr_flags = bus_wr && (bus_addr == ADR_FLAGS);
    assign rd_ofs   = bus_rd && (bus_addr == ADR_OFFSET);
    assign ofs_mask = (code == '0) ? '0
                    : ({{(NPINS-1){1'b0}}, 1'b1} << (code - 1'b1));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == '0));

    assert_only_edges_set_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flags & ~$past(flags) & ~$past(hits)) == '0));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        wr_flags |=> ((flags & $past(bus_wdata) & ~$past(hits)) == '0));

    assert_masked_no_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq);

    assert_offset_data_R8: assert property (@(posedge clk) disable iff (rst)
        rd_ofs |=> (bus_rdata == NPINS'($past(code))));

    assert_offset_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rd_ofs |=> ((flags & $past(ofs_mask) & ~$past(hits)) == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flags & $past(hits)) == $past(hits)));

endmodule

bind gpio_edge_flags gpio_edge_flags_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flags     (flag_q),
    .hits      (hit_w),
    .enable    (cfg_q.enable),
    .code      (ofs_code),
    .irq       (irq),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
);

// File: tb/gpio_edge_flags_test.sv
`timescale 1ns/1ps
module gpio_edge_flags_test;
    import gpio_flag_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NPINS-1:0]  pin_in = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [NPINS-1:0]  bus_wdata = '0;
    logic [NPINS-1:0]  bus_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_edge_flags uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        wr(ADR_FLAGS, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(ADR_FLAGS, d);  check("R1 flags", d, 32'h0);
        rd(ADR_OFFSET, d); check("R1 offset", d, 32'h0);
        rd(ADR_ENABLE, d); check("R1 enable", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(ADR_ENABLE, 32'hA5A5_0F0F);
        wr(ADR_BOTH, 32'h1234_5678);
        wr(ADR_POL, 32'hFFFF_0000);
        rd(ADR_ENABLE, d); check("R10 enable", d, 32'hA5A5_0F0F);
        rd(ADR_BOTH, d);   check("R10 both", d, 32'h1234_5678);
        rd(ADR_POL, d);    check("R10 pol", d, 32'hFFFF_0000);
        wr(ADR_ENABLE, 0); wr(ADR_BOTH, 0); wr(ADR_POL, 0);
    endtask

    task automatic t_rising();
        logic [31:0] d;
        wr(ADR_POL, 32'hFFFF_FFFF);
        drive_pins(32'h0000_0001);
        rd(ADR_FLAGS, d); check("R2 rise sets", d, 32'h0000_0001);
        clear_all();
        drive_pins(32'h0);
        rd(ADR_FLAGS, d); check("R2 fall ignored", d, 32'h0);
    endtask

    task automatic t_falling();
        logic [31:0] d;
        wr(ADR_POL, 32'h0);
        drive_pins(32'h0000_0100);
        rd(ADR_FLAGS, d); check("R3 rise ignored", d, 32'h0);
        drive_pins(32'h0);
        rd(ADR_FLAGS, d); check("R3 fall sets", d, 32'h0000_0100);
        clear_all();
    endtask

    task automatic t_both();
        logic [31:0] d;
        wr(ADR_BOTH, 32'h0001_0000);
        wr(ADR_POL, 32'h0);
        drive_pins(32'h0001_0000);
        rd(ADR_FLAGS, d); check("R4 rise sets", d, 32'h0001_0000);
        clear_all();
        wr(ADR_POL, 32'h0001_0000);
        drive_pins(32'h0);
        rd(ADR_FLAGS, d); check("R4 fall sets", d, 32'h0001_0000);
        clear_all();
        wr(ADR_BOTH, 0); wr(ADR_POL, 0);
    endtask

    task automatic t_latency();
        wr(ADR_POL, 32'h0000_0004);
        wr(ADR_ENABLE, 32'h0000_0004);
        @(negedge clk);
        pin_in = 32'h0000_0004;
        @(posedge clk); @(posedge clk); #2;
        check("R5 not yet", {31'b0, irq}, 32'h0);
        @(posedge clk); #2;
        check("R5 on third edge", {31'b0, irq}, 32'h1);
        clear_all();
        drive_pins(32'h0);
        wr(ADR_ENABLE, 0); wr(ADR_POL, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(ADR_BOTH, 32'h0000_00F0);
        drive_pins(32'h0000_00F0);
        wr(ADR_FLAGS, 32'h0000_0050);
        rd(ADR_FLAGS, d); check("R6 partial clear", d, 32'h0000_00A0);
        wr(ADR_FLAGS, 32'h0);
        rd(ADR_FLAGS, d); check("R6 zero write", d, 32'h0000_00A0);
        clear_all();
        drive_pins(32'h0);
        clear_all();
        wr(ADR_BOTH, 0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(ADR_POL, 32'h0000_0008);
        drive_pins(32'h0000_0008);
        rd(ADR_FLAGS, d); check("R7 flag while disabled", d, 32'h0000_0008);
        check("R7 irq low", {31'b0, irq}, 32'h0);
        wr(ADR_ENABLE, 32'h0000_0008);
        check("R7 irq high", {31'b0, irq}, 32'h1);
        clear_all();
        check("R7 irq drops", {31'b0, irq}, 32'h0);
        drive_pins(32'h0);
        wr(ADR_ENABLE, 0); wr(ADR_POL, 0);
    endtask

    task automatic t_offset();
        logic [31:0] d;
        wr(ADR_POL, 32'hFFFF_FFFF);
        wr(ADR_ENABLE, 32'h4000_0408);
        drive_pins(32'h4000_040A);
        rd(ADR_FLAGS, d);  check("R11 mapping", d, 32'h4000_040A);
        rd(ADR_OFFSET, d); check("R8 first", d, 32'd4);
        rd(ADR_OFFSET, d); check("R8 second", d, 32'd11);
        rd(ADR_OFFSET, d); check("R8 third", d, 32'd31);
        rd(ADR_OFFSET, d); check("R8 none", d, 32'd0);
        rd(ADR_FLAGS, d);  check("R8 disabled kept", d, 32'h0000_0002);
        clear_all();
        drive_pins(32'h0);
        wr(ADR_ENABLE, 0); wr(ADR_POL, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        wr(ADR_BOTH, 32'h0000_0020);
        wr(ADR_ENABLE, 32'h0000_0020);
        drive_pins(32'h0000_0020);
        @(negedge clk);
        pin_in = 32'h0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = ADR_FLAGS; bus_wdata = 32'h0000_0020; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd(ADR_FLAGS, d); check("R9 write collision", d, 32'h0000_0020);
        @(negedge clk);
        pin_in = 32'h0000_0020;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = ADR_OFFSET; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R9 offset code", bus_rdata, 32'd6);
        rd(ADR_FLAGS, d); check("R9 offset collision", d, 32'h0000_0020);
        clear_all();
        rd(ADR_FLAGS, d); check("R6 clear after", d, 32'h0);
        drive_pins(32'h0);
        clear_all();
        wr(ADR_BOTH, 0); wr(ADR_ENABLE, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_rising();
        t_falling();
        t_both();
        t_latency();
        t_w1c();
        t_enable();
        t_offset();
        t_set_wins();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule